// File: doc/BRIEF.md
# Pipelined Complex Multiplier with Rounding and Saturation

This block multiplies a stream of complex samples by a matching stream of complex reference values, one pair per clock, as needed when a received signal is multiplied by a reference function before compression. Each full-precision product sum is brought back to the output word length by a selectable right shift with round-half-up. Results that do not fit are clamped to the output range instead of wrapping.

A mode input turns the same four multipliers into a detector. In that mode the reference operand is ignored, the sample is multiplied by itself, and the block returns the scaled squared magnitude on the real output with a zero imaginary output. Mode and shift travel with each sample, so they may change from one cycle to the next without disturbing results already in flight.

Top module: `cmul_top`

## Requirements
- R1: In multiply mode (mode_det = 0) the real output is round_sat(a_re*b_re - a_im*b_im), where all operands are signed two's complement 16-bit values.
- R2: In multiply mode the imaginary output is round_sat(a_re*b_im + a_im*b_re).
- R3: round_sat with shift s computes floor((x + 2^(s-1)) / 2^s) for s > 0, so halves round toward plus infinity; s = 0 passes x unchanged before the limit.
- R4: A rounded value above 32767 is output as 32767, and one below -32768 as -32768.
- R5: In detection mode (mode_det = 1) the real output is round_sat(a_re^2 + a_im^2), is never negative, and b_re/b_im have no effect.
- R6: In detection mode the imaginary output is 0.
- R7: A sample presented with in_valid = 1 before clock edge n appears on the outputs after edge n+2, with out_valid = 1; out_valid follows in_valid delayed by exactly three cycles.
- R8: While out_valid = 0, y_re and y_im keep the last valid result; inputs presented with in_valid = 0 do not change the outputs.
- R9: A shift input greater than 16 is treated as 16.
- R10: While rst is high at a clock edge, out_valid, y_re and y_im are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the inputs of this cycle as a sample |
| mode_det | input | 1 | 0 = complex multiply, 1 = squared-magnitude detection |
| shift | input | 5 | Right shift applied before rounding, 0 to 16 (larger values clamp) |
| a_re | input | 16 | Sample, real part, signed |
| a_im | input | 16 | Sample, imaginary part, signed |
| b_re | input | 16 | Reference, real part, signed |
| b_im | input | 16 | Reference, imaginary part, signed |
| out_valid | output | 1 | Result on y_re/y_im is new this cycle |
| y_re | output | 16 | Result, real part, signed |
| y_im | output | 16 | Result, imaginary part, signed |

## Verification
A stage that loaded while its valid was low, or a mode or shift flag that slipped one stage against its data, shows up at the ports three cycles after the offending input as a result that mixes two samples or uses the wrong formula. A valid bit dropped or duplicated in the chain appears as out_valid disagreeing with in_valid from three cycles earlier, and a wrong rounding bias or clamp shows only on directed half-way and extreme operands, which the stimulus therefore forces.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    localparam int DW    = 16;           // input component width
    localparam int OW    = 16;           // output component width
    localparam int SHW   = 5;            // shift control width
    localparam int MAXSH = 16;           // largest shift honoured
    localparam int PW    = 2 * DW;       // product width
    localparam int SW    = PW + 1;       // sum width
    localparam int RW    = SW + 1;       // rounding headroom

    localparam logic signed [RW-1:0] R_MAX = RW'(2 ** (OW - 1) - 1);
    localparam logic signed [RW-1:0] R_MIN = RW'(-(2 ** (OW - 1)));

    typedef enum logic {MODE_MUL = 1'b0, MODE_DET = 1'b1} mode_e;

    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } cplx_t;

    typedef struct packed {
        logic signed [PW-1:0] rr;
        logic signed [PW-1:0] ii;
        logic signed [PW-1:0] ri;
        logic signed [PW-1:0] ir;
        mode_e                mode;
        logic [SHW-1:0]       sh;
    } prod_t;

    typedef struct packed {
        logic signed [SW-1:0] re;
        logic signed [SW-1:0] im;
        mode_e                mode;
        logic [SHW-1:0]       sh;
    } sum_t;

    // shift right with round-half-up, then clamp to the output range
    function automatic logic signed [OW-1:0] round_sat(input logic signed [SW-1:0] v,
                                                       input logic [SHW-1:0] sh);
        logic signed [RW-1:0] ext;
        logic signed [RW-1:0] bias;
        logic signed [RW-1:0] r;
        ext  = RW'(v);
        bias = (sh == '0) ? '0 : (RW'(1) <<< (sh - 1'b1));
        r    = (ext + bias) >>> sh;
        if (r > R_MAX)      r = R_MAX;
        else if (r < R_MIN) r = R_MIN;
        return OW'(r);
    endfunction

endpackage

// File: rtl/cmul_prod.sv
module cmul_prod
    import cmul_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           v_in,
    input  cplx_t          a,
    input  cplx_t          b,
    input  mode_e          mode,
    input  logic [SHW-1:0] sh,
    output logic           v_out,
    output prod_t          p
);
    cplx_t b_eff;

    // detection reuses the multipliers with the sample as second operand
    always_comb b_eff = (mode == MODE_DET) ? a : b;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_out <= 1'b0;
            p     <= '0;
        end else begin
            v_out <= v_in;
            if (v_in) begin
                p.rr   <= a.re * b_eff.re;
                p.ii   <= a.im * b_eff.im;
                p.ri   <= a.re * b_eff.im;
                p.ir   <= a.im * b_eff.re;
                p.mode <= mode;
                p.sh   <= sh;
            end
        end
    end
endmodule

// File: rtl/cmul_sum.sv
module cmul_sum
    import cmul_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  v_in,
    input  prod_t p,
    output logic  v_out,
    output sum_t  s
);
    logic signed [SW-1:0] rr_x, ii_x, ri_x, ir_x;

    always_comb begin
        rr_x = SW'(p.rr);
        ii_x = SW'(p.ii);
        ri_x = SW'(p.ri);
        ir_x = SW'(p.ir);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_out <= 1'b0;
            s     <= '0;
        end else begin
            v_out <= v_in;
            if (v_in) begin
                if (p.mode == MODE_DET) begin
                    s.re <= rr_x + ii_x;
                    s.im <= '0;
                end else begin
                    s.re <= rr_x - ii_x;
                    s.im <= ri_x + ir_x;
                end
                s.mode <= p.mode;
                s.sh   <= p.sh;
            end
        end
    end
endmodule

// File: rtl/cmul_out.sv
module cmul_out
    import cmul_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 v_in,
    input  sum_t                 s,
    output logic                 v_out,
    output logic signed [OW-1:0] y_re,
    output logic signed [OW-1:0] y_im
);
    mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_out  <= 1'b0;
            y_re   <= '0;
            y_im   <= '0;
            mode_q <= MODE_MUL;
        end else begin
            v_out <= v_in;
            if (v_in) begin
                y_re   <= round_sat(s.re, s.sh);
                y_im   <= round_sat(s.im, s.sh);
                mode_q <= s.mode;
            end
        end
    end

    // R6
    det_imag_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (v_out && mode_q == MODE_DET) |-> (y_im == '0));

    // R5
    det_real_nonneg_chk: assert property (@(posedge clk) disable iff (rst)
        (v_out && mode_q == MODE_DET) |-> !y_re[OW-1]);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !v_in |=> ($stable(y_re) && $stable(y_im)));
endmodule

// File: rtl/cmul_top.sv
module cmul_top
    import cmul_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 mode_det,
    input  logic [SHW-1:0]       shift,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    output logic                 out_valid,
    output logic signed [OW-1:0] y_re,
    output logic signed [OW-1:0] y_im
);
    cplx_t          a_c, b_c;
    mode_e          mode_c;
    logic [SHW-1:0] sh_c;
    logic           v1, v2;
    prod_t          p1;
    sum_t           s2;

    always_comb begin
        a_c.re = a_re;
        a_c.im = a_im;
        b_c.re = b_re;
        b_c.im = b_im;
        mode_c = mode_det ? MODE_DET : MODE_MUL;
        sh_c   = (shift > SHW'(MAXSH)) ? SHW'(MAXSH) : shift;
    end

    cmul_prod u_prod (
        .clk(clk), .rst(rst), .v_in(in_valid), .a(a_c), .b(b_c),
        .mode(mode_c), .sh(sh_c), .v_out(v1), .p(p1)
    );

    cmul_sum u_sum (
        .clk(clk), .rst(rst), .v_in(v1), .p(p1), .v_out(v2), .s(s2)
    );

    cmul_out u_out (
        .clk(clk), .rst(rst), .v_in(v2), .s(s2),
        .v_out(out_valid), .y_re(y_re), .y_im(y_im)
    );

    // cycles since reset, saturating at the pipeline depth
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                   since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R7
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && y_re == '0 && y_im == '0));
endmodule

// File: tb/cmul_top_test.sv
module cmul_top_test;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic               mode_det = 1'b0;
    logic [4:0]         shift = '0;
    logic signed [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic               out_valid;
    logic signed [15:0] y_re, y_im;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int    q_re[$];
    int    q_im[$];
    string q_tag[$];
    bit    vh[$];
    int    last_re = 0, last_im = 0;

    always #10 clk = ~clk;

    cmul_top uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode_det(mode_det), .shift(shift),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .out_valid(out_valid), .y_re(y_re), .y_im(y_im)
    );

    function automatic int rs(input longint v, input int s);
        longint b, r;
        b = (s == 0) ? 64'sd0 : (64'sd1 <<< (s - 1));
        r = (v + b) >>> s;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic observe();
        int yr, yi;
        yr = int'(y_re);
        yi = int'(y_im);
        if (vh.size() >= 3) begin
            chk("R7 out_valid", int'(out_valid), int'(vh[0]));
            void'(vh.pop_front());
        end
        if (out_valid) begin
            if (q_re.size() > 0) begin
                chk({q_tag[0], " re"}, yr, q_re[0]);
                chk({q_tag[0], " im"}, yi, q_im[0]);
                void'(q_re.pop_front());
                void'(q_im.pop_front());
                void'(q_tag.pop_front());
            end
        end else begin
            chk("R8 hold re", yr, last_re);
            chk("R8 hold im", yi, last_im);
        end
        last_re = yr;
        last_im = yi;
    endtask

    task automatic step(input bit v, input bit det, input int sh,
                        input int ar, input int ai, input int br, input int bi,
                        input string tag);
        longint re, im;
        int s;
        @(negedge clk);
        observe();
        in_valid = v;
        mode_det = det;
        shift    = 5'(sh);
        a_re = 16'(ar); a_im = 16'(ai); b_re = 16'(br); b_im = 16'(bi);
        vh.push_back(v);
        if (v) begin
            s = (sh > 16) ? 16 : sh;
            if (det) begin
                re = longint'(ar) * ar + longint'(ai) * ai;
                im = 0;
            end else begin
                re = longint'(ar) * br - longint'(ai) * bi;
                im = longint'(ar) * bi + longint'(ai) * br;
            end
            q_re.push_back(rs(re, s));
            q_im.push_back(rs(im, s));
            q_tag.push_back(tag);
        end
    endtask

    function automatic int rnd16();
        return int'($signed(16'($urandom)));
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // feed garbage while in reset
        a_re = 16'sd1234; b_re = 16'sd77; in_valid = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 out_valid", int'(out_valid), 0);
        chk("R10 y_re", int'(y_re), 0);
        chk("R10 y_im", int'(y_im), 0);
        rst = 1'b0;
        in_valid = 1'b0;
        vh.push_back(1'b0); vh.push_back(1'b0); vh.push_back(1'b0);

        // directed corners
        step(1, 0, 0, 3, 4, 5, 6, "R1/R2 basic");
        step(1, 0, 1, 3, 0, 1, 0, "R3 half up pos");
        step(1, 0, 1, -3, 0, 1, 0, "R3 half up neg");
        step(1, 0, 2, 6, 0, 1, 1, "R3 shift2");
        step(1, 0, 0, -32768, -32768, -32768, 32767, "R4 sat high");
        step(1, 0, 0, -32768, 32767, 32767, 32767, "R4 sat low");
        step(0, 1, 3, 999, 999, 999, 999, "R8 idle");
        step(0, 0, 0, -5, 7, 100, 9, "R8 idle");
        step(1, 0, 31, 32767, 0, 32767, 0, "R9 shift clamp");
        step(1, 0, 17, -32768, 0, 32767, 0, "R9 shift clamp");
        step(1, 1, 16, -32768, -32768, 5, 5, "R5/R6 det");
        step(1, 1, 0, 100, -200, 32767, -32768, "R5/R6 det b ignored");
        step(1, 1, 4, -7, 3, 0, 0, "R5/R6 det small");
        step(1, 1, 0, 0, 0, 1, 1, "R5/R6 det zero");

        // constrained random traffic
        for (int i = 0; i < 600; i++) begin
            bit v, det;
            int sh;
            v   = ($urandom % 5) != 0;
            det = ($urandom % 4) == 0;
            sh  = ($urandom % 3 == 0) ? int'($urandom % 32) : int'(15 + $urandom % 2);
            step(v, det, sh, rnd16(), rnd16(), rnd16(), rnd16(),
                 det ? "R5/R6 rand" : "R1/R2 rand");
        end

        // drain
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 0, "drain");
        chk("R7 all results seen", q_re.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule